// File: doc/BRIEF.md
# Scan Chain Fault Bound Locator

This block narrows down where a single stuck-at defect sits inside one scan chain. An earlier flush test, which shifts a repeating 11001100 stream through the chain, has already shown that the chain is broken and whether the defect is stuck-at-0 or stuck-at-1. A test pattern is then captured into the chain and shifted out. This block receives those serial bits together with the fault-free response expected for each cell. It reports a pair of cell indices that bracket the defective cell.

Cells are numbered 0 at the scan-out end and N-1 at the scan-in end, so the first bit shifted out belongs to cell 0. The block compares the bits in that order. The first disagreement sets the upper bound. The lower bound is the last agreeing cell before that disagreement whose expected value is the opposite of the stuck value. Only such a cell proves that the defect lies further toward scan-in. The defect then lies strictly between the two bounds, or in the upper-bound cell itself. If the whole chain agrees, the block reports that no fault was observed.

A start pulse loads the length, the fault type and the expected response. The block then takes one bit on each cycle that the valid strobe is high. A done pulse marks the moment the results are published.

Top module: `scanBoundLocator`

## Requirements
- R1: The first valid bit accepted after a start pulse belongs to cell 0. The k-th valid bit is compared with bit k-1 of the `golden` vector that was latched at start.
- R2: When the done pulse is high and `noFault` is 0, `upperIdx` holds the index of the first cell whose shifted-out bit differs from its golden bit.
- R3: `lowerIdx` is the highest-indexed cell below the upper bound whose bit matched and whose golden bit is not the stuck value. `stuckHigh`=1 means stuck-at-1 and `stuckHigh`=0 means stuck-at-0. Bits after the first mismatch do not change any result.
- R4: When no cell below the upper bound qualifies as a lower-bound match, `lowerFound` is 0 and `lowerIdx` is 0.
- R5: When every cell of the chain matches, `noFault` is 1 and `upperIdx`, `lowerIdx` and `lowerFound` are all 0. Otherwise `noFault` is 0.
- R6: `done` is high for exactly one cycle. That cycle follows the clock edge that accepts the last valid bit of the chain.
- R7: `upperIdx`, `lowerIdx`, `lowerFound` and `noFault` change only at the edge that raises `done`. Between done pulses, including across a new start pulse, they hold their values.
- R8: A `chainLen` of 0, or one greater than N, is treated as a chain of N cells. Any other value sets the number of bits taken.
- R9: Cycles with `scanValid` low do not advance the cell index. Valid bits that arrive while no run is active are ignored.
- R10: A start pulse during a run abandons that run and begins a new one from cell 0.
- R11: After reset, `done`, `upperIdx`, `lowerIdx`, `lowerFound` and `noFault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that loads the run parameters and begins a run |
| chainLen | input | $clog2(N+1) | Number of cells in the chain; 0 or a value above N means N |
| stuckHigh | input | 1 | Fault type found by the flush test: 1 for stuck-at-1, 0 for stuck-at-0 |
| golden | input | N | Fault-free response; bit i is the expected value of cell i |
| scanBit | input | 1 | Serial bit shifted out of the chain |
| scanValid | input | 1 | High when `scanBit` carries the next cell's value |
| upperIdx | output | $clog2(N) | Upper-bound cell index |
| lowerIdx | output | $clog2(N) | Lower-bound cell index |
| lowerFound | output | 1 | High when a lower bound exists |
| noFault | output | 1 | High when the whole chain matched its golden response |
| done | output | 1 | One-cycle pulse when results are published |

## Verification
A stuck-at-0 chain with the defect in the middle shows whether both bounds are found and whether the defect ends up strictly between them. A stuck-at-1 case in which every match carries the stuck value checks that the lower-bound flag stays low. A mismatch at cell 0 and a chain that fully matches test the two ends of the index range. Short chains, a zero length, gapped valid strobes, stray bits while idle and a restart in mid-run check that bits are assigned to the correct cells. The behavioural model replays each run and checks every output on every cycle, so any early, late or spurious change of a result is caught.

// File: rtl/scanBoundPkg.sv
package scanBoundPkg;
  // Strobes from the sequencer to the comparison datapath.
  typedef struct packed {
    logic load;    // latch golden vector and fault type, clear working state
    logic step;    // one accepted bit for the current cell index
    logic finish;  // this step is the last cell: publish the results
  } dpStrobe_t;
endpackage

// File: rtl/scanBoundCtrl.sv
module scanBoundCtrl
  import scanBoundPkg::*;
#(
  parameter int N = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [$clog2(N+1)-1:0]       chainLen,
  input  logic                         scanValid,
  output dpStrobe_t                    strobe,
  output logic [$clog2(N)-1:0]         cellIdx,
  output logic                         done
);
  localparam int LENW = $clog2(N + 1);
  localparam int IDXW = $clog2(N);
  localparam logic [LENW-1:0] FULL_LEN = LENW'(N);

  typedef enum logic {IDLE, BUSY} ctrlState_t;

  ctrlState_t        state;
  logic [LENW-1:0]   lenEff;
  logic [IDXW-1:0]   count;
  logic [LENW-1:0]   startLen;
  logic              lastCell;

  // Out-of-range length falls back to the full chain.
  always_comb begin
    if (chainLen == '0 || chainLen > FULL_LEN) startLen = FULL_LEN;
    else                                       startLen = chainLen;
  end

  assign lastCell      = (LENW'(count) == lenEff - LENW'(1));
  assign strobe.load   = start;
  assign strobe.step   = (state == BUSY) && scanValid && !start;
  assign strobe.finish = strobe.step && lastCell;
  assign cellIdx       = count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= IDLE;
      lenEff <= FULL_LEN;
      count  <= '0;
      done   <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (start) begin
        state  <= BUSY;
        lenEff <= startLen;
        count  <= '0;
      end else if (strobe.step) begin
        if (lastCell) begin
          state <= IDLE;
          count <= '0;
        end else begin
          count <= count + IDXW'(1);
        end
      end
    end
  end

  // The running index never walks past the configured chain (R1, R8).
  assert_idx_in_chain_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == BUSY) |-> (LENW'(count) < lenEff));

  // Done is a single-cycle pulse (R6).
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // A finishing step returns the sequencer to idle unless restarted (R6).
  assert_finish_to_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !start) |=> (state == IDLE));

  // Idle cycles never consume a bit (R9).
  assert_idle_no_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == IDLE) |-> !strobe.step);

  // A restart always rewinds to cell 0 (R10).
  assert_restart_rewind_R10: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (count == '0 && state == BUSY));
endmodule

// File: rtl/scanBoundPath.sv
module scanBoundPath
  import scanBoundPkg::*;
#(
  parameter int N = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [$clog2(N)-1:0]   cellIdx,
  input  logic [N-1:0]           golden,
  input  logic                   stuckHigh,
  input  logic                   scanBit,
  output logic [$clog2(N)-1:0]   upperIdx,
  output logic [$clog2(N)-1:0]   lowerIdx,
  output logic                   lowerFound,
  output logic                   noFault
);
  localparam int IDXW = $clog2(N);

  logic [N-1:0]    goldReg;
  logic            stuckReg;
  // Working state for the run in progress.
  logic            seenMiss;
  logic [IDXW-1:0] upWork;
  logic [IDXW-1:0] loWork;
  logic            loWorkValid;

  // Next-state values including the bit arriving now.
  logic            curGold;
  logic            isMiss;
  logic            isProof;
  logic            nSeen;
  logic [IDXW-1:0] nUp;
  logic [IDXW-1:0] nLo;
  logic            nLoValid;

  always_comb begin
    curGold  = goldReg[cellIdx];
    isMiss   = (scanBit != curGold);
    // A matching cell whose golden value differs from the stuck value shows
    // that the stuck cell is further toward scan-in.
    isProof  = !isMiss && (curGold != stuckReg);
    nSeen    = seenMiss | isMiss;
    nUp      = (!seenMiss && isMiss)  ? cellIdx : upWork;
    nLo      = (!seenMiss && isProof) ? cellIdx : loWork;
    nLoValid = loWorkValid | (!seenMiss && isProof);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goldReg     <= '0;
      stuckReg    <= 1'b0;
      seenMiss    <= 1'b0;
      upWork      <= '0;
      loWork      <= '0;
      loWorkValid <= 1'b0;
    end else if (strobe.load) begin
      goldReg     <= golden;
      stuckReg    <= stuckHigh;
      seenMiss    <= 1'b0;
      upWork      <= '0;
      loWork      <= '0;
      loWorkValid <= 1'b0;
    end else if (strobe.step) begin
      seenMiss    <= nSeen;
      upWork      <= nUp;
      loWork      <= nLo;
      loWorkValid <= nLoValid;
    end
  end

  // Published results move only on the finishing step.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperIdx   <= '0;
      lowerIdx   <= '0;
      lowerFound <= 1'b0;
      noFault    <= 1'b0;
    end else if (strobe.finish) begin
      noFault    <= !nSeen;
      upperIdx   <= nSeen ? nUp : '0;
      lowerIdx   <= (nSeen && nLoValid) ? nLo : '0;
      lowerFound <= nSeen && nLoValid;
    end
  end

  // Lower bound sits strictly below the upper bound (R3).
  assert_lower_below_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    lowerFound |-> (lowerIdx < upperIdx));

  // Without a lower bound the index reads zero (R4).
  assert_no_lower_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !lowerFound |-> (lowerIdx == '0));

  // A clean chain reports no bounds (R5).
  assert_clean_no_bounds_R5: assert property (@(posedge clk) disable iff (!rstN)
    noFault |-> (!lowerFound && upperIdx == '0));

  // Once a mismatch is recorded its index stays frozen for the run (R2).
  assert_upper_frozen_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seenMiss && strobe.step && !strobe.load) |=> $stable(upWork));

  // Results hold between finishing steps (R7).
  assert_results_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable({upperIdx, lowerIdx, lowerFound, noFault}));
endmodule

// File: rtl/scanBoundLocator.sv
module scanBoundLocator
  import scanBoundPkg::*;
#(
  parameter int N = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [$clog2(N+1)-1:0]       chainLen,
  input  logic                         stuckHigh,
  input  logic [N-1:0]                 golden,
  input  logic                         scanBit,
  input  logic                         scanValid,
  output logic [$clog2(N)-1:0]         upperIdx,
  output logic [$clog2(N)-1:0]         lowerIdx,
  output logic                         lowerFound,
  output logic                         noFault,
  output logic                         done
);
  localparam int IDXW = $clog2(N);

  dpStrobe_t       strobe;
  logic [IDXW-1:0] cellIdx;

  scanBoundCtrl #(.N(N)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .chainLen  (chainLen),
    .scanValid (scanValid),
    .strobe    (strobe),
    .cellIdx   (cellIdx),
    .done      (done)
  );

  scanBoundPath #(.N(N)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cellIdx    (cellIdx),
    .golden     (golden),
    .stuckHigh  (stuckHigh),
    .scanBit    (scanBit),
    .upperIdx   (upperIdx),
    .lowerIdx   (lowerIdx),
    .lowerFound (lowerFound),
    .noFault    (noFault)
  );

  // Results only appear together with the done pulse (R6, R7).
  assert_results_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({upperIdx, lowerIdx, lowerFound, noFault}));
endmodule

// File: tb/test_scanBoundLocator.sv
module test_scanBoundLocator;
  localparam int N = 7;
  localparam int LENW = $clog2(N + 1);
  localparam int IDXW = $clog2(N);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LENW-1:0] chainLen = '0;
  logic stuckHigh = 1'b0;
  logic [N-1:0] golden = '0;
  logic scanBit = 1'b0;
  logic scanValid = 1'b0;
  logic [IDXW-1:0] upperIdx, lowerIdx;
  logic lowerFound, noFault, done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  scanBoundLocator #(.N(N)) i_scanBoundLocator (
    .clk(clk), .rstN(rstN), .start(start), .chainLen(chainLen),
    .stuckHigh(stuckHigh), .golden(golden), .scanBit(scanBit),
    .scanValid(scanValid), .upperIdx(upperIdx), .lowerIdx(lowerIdx),
    .lowerFound(lowerFound), .noFault(noFault), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit mBusy = 0;
  int mLen = N;
  logic [N-1:0] mGold;
  bit mStuck;
  bit rx[$];
  int eUp = 0, eLo = 0;
  bit eLf = 0, eNf = 0, eDone = 0;

  function automatic void evaluate();
    bit seen = 0;
    int up = 0, lo = 0;
    bit lf = 0;
    foreach (rx[i]) begin
      if (!seen) begin
        if (rx[i] != mGold[i]) begin seen = 1; up = i; end
        else if (mGold[i] != mStuck) begin lf = 1; lo = i; end
      end
    end
    if (!seen) begin eNf = 1; eUp = 0; eLo = 0; eLf = 0; end
    else begin eNf = 0; eUp = up; eLf = lf; eLo = lf ? lo : 0; end
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; eUp = 0; eLo = 0; eLf = 0; eNf = 0; eDone = 0;
      rx.delete();
    end else begin
      eDone = 0;
      if (start) begin
        mBusy = 1;
        rx.delete();
        mLen = (chainLen == 0 || chainLen > N) ? N : int'(chainLen);
        mGold = golden;
        mStuck = stuckHigh;
      end else if (mBusy && scanValid) begin
        rx.push_back(scanBit);
        if (rx.size() == mLen) begin
          evaluate();
          mBusy = 0;
          eDone = 1;
        end
      end
    end
  end

  // Every-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(done == eDone, "R6 done", done, eDone);
      check(upperIdx == eUp, "R2 upperIdx", upperIdx, eUp);
      check(lowerIdx == eLo, "R3 lowerIdx", lowerIdx, eLo);
      check(lowerFound == eLf, "R4 lowerFound", lowerFound, eLf);
      check(noFault == eNf, "R5 noFault", noFault, eNf);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic beginRun(input int len, input logic [N-1:0] gold, input bit stuck);
    @(negedge clk);
    start = 1; chainLen = LENW'(len); golden = gold; stuckHigh = stuck;
    @(negedge clk);
    start = 0; golden = ~gold; // later changes must not matter (R1)
  endtask

  // Sends bits obs[0..nbits-1]; leaves time at the negedge after the last bit.
  task automatic sendBits(input logic [N-1:0] obs, input int nbits, input bit gaps);
    for (int i = 0; i < nbits; i++) begin
      if (gaps) begin
        scanValid = 0; scanBit = ~obs[i];
        @(negedge clk);
      end
      scanValid = 1; scanBit = obs[i];
      @(negedge clk);
    end
    scanValid = 0;
  endtask

  task automatic expectResult(input string tag, input int up, input int lo,
                              input bit lf, input bit nf);
    check(upperIdx == up, {tag, " upper"}, upperIdx, up);
    check(lowerIdx == lo, {tag, " lower"}, lowerIdx, lo);
    check(lowerFound == lf, {tag, " lowerFound"}, lowerFound, lf);
    check(noFault == nf, {tag, " noFault"}, noFault, nf);
  endtask

  // Watchdog: a hung run counts as a failure.
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    check(done == 0, "R11 done", done, 0);
    expectResult("R11", 0, 0, 0, 0);
    rstN = 1;
    @(negedge clk);

    // R9: valid bits while idle are ignored
    sendBits(7'b1111111, 3, 0);
    check(done == 0, "R9 idle bits", done, 0);

    // Stuck-at-0 defect at cell 4: golden cells 0..6 = 1,0,1,1,0,1,1
    // observed 1,0,1,1,0,0,0 -> upper 5, lower 3 (R2, R3, R1)
    beginRun(7, 7'b1101101, 0);
    sendBits(7'b0001101, 7, 0);
    check(done == 1, "R6 pulse after last bit", done, 1);
    expectResult("R2 R3 sa0 mid", 5, 3, 1, 0);
    @(negedge clk);
    check(done == 0, "R6 single cycle", done, 0);

    // R7: new start keeps old results until the next done
    beginRun(7, 7'b0000000, 1);
    sendBits(7'b0000000, 3, 0);
    expectResult("R7 held across start", 5, 3, 1, 0);
    // R10: restart mid-run; stuck-at-1, cells 0..2 golden 1, cell 3 golden 0 seen 1
    beginRun(7, 7'b0110111, 1);
    sendBits(7'b1111111, 7, 0);
    expectResult("R4 R10 no lower bound", 3, 0, 0, 0);

    // R5: clean chain
    beginRun(7, 7'b1010011, 0);
    sendBits(7'b1010011, 7, 1);
    expectResult("R5 clean", 0, 0, 0, 1);

    // R2: mismatch at cell 0; later bits irrelevant (R3)
    beginRun(7, 7'b1111110, 1);
    sendBits(7'b0101011, 7, 0);
    expectResult("R2 cell0", 0, 0, 0, 0);

    // R8 + R9: short chain of 4 with gaps; sa1 golden 0,1,0,1 seen 0,1,1,1
    beginRun(4, 7'b0001010, 1);
    sendBits(7'b1111110, 4, 1);
    check(done == 1, "R8 length 4 done", done, 1);
    expectResult("R8 len4", 2, 0, 1, 0);

    // R8: zero length means N cells; done must not come after 4 bits
    beginRun(0, 7'b1111111, 0);
    sendBits(7'b0001111, 4, 0);
    check(done == 0, "R8 zero length not early", done, 0);
    sendBits(7'b0000000, 3, 0);
    check(done == 1, "R8 zero length done", done, 1);
    expectResult("R8 len0", 4, 3, 1, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule